// File: doc/BRIEF.md
# Digital Phase Lock Detector with Hysteresis

This block decides whether a phase-locked loop has settled. Once per phase-detector cycle, it measures how far apart the rising edges of the divided reference clock and the divided feedback clock are. The distance is counted in ticks of a fast measurement clock. Both divided clocks are asynchronous to that clock, so each passes through an identical synchronizer before any edge is detected. Because both paths have the same latency, the tick distance between the two edges is preserved.

Every completed measurement falls into one of three classes. A small error lies below the set threshold. A large error lies above the clear threshold. Anything between the two thresholds is the middle band. A run of consecutive small-error cycles raises the active-high lock flag. The run must be three cycles long, or five when the precision select is high. A single large-error cycle drops the flag. A middle-band cycle restarts the run but leaves an existing lock in place. This gives hysteresis between the two thresholds.

A cycle whose second edge never comes within a timeout window counts as a large error. A cycle whose leading input repeats before its partner arrives also counts as a large error. Power-down clears all of the detector's state.

Top module: `phase_lock_monitor`

## Requirements
- R1: While `rst` or `pwr_down` is high, `lock_out` reads 0 one cycle later, and the run of small-error cycles starts again from zero.
- R2: With `precise_sel` = 0, `lock_out` rises after the third consecutive measurement whose error is strictly less than `SET_TICKS`, and not before.
- R3: With `precise_sel` = 1, five consecutive small-error measurements are needed before `lock_out` rises.
- R4: Once high, `lock_out` stays high through small-error and middle-band measurements.
- R5: A single measurement whose error is strictly greater than `CLR_TICKS` drives `lock_out` to 0.
- R6: A middle-band error (`SET_TICKS` <= error <= `CLR_TICKS`) restarts the consecutive count without clearing an existing lock.
- R7: Two cases count as a large error. In the first, one input's edge is not followed by the other's within `TIMEOUT_TICKS` ticks. In the second, the leading input's edge repeats before the partner arrives.
- R8: The error is the absolute tick distance between the two rising edges, whichever input leads. Coincident edges give an error of 0.
- R9: Boundary classification. An error equal to `SET_TICKS` is not small. An error equal to `CLR_TICKS` is not large.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Power-down; clears all detector state while high |
| precise_sel | input | 1 | 0: three good cycles to lock; 1: five |
| ref_div_in | input | 1 | Divided reference clock, asynchronous |
| fb_div_in | input | 1 | Divided feedback clock, asynchronous |
| lock_out | output | 1 | Active-high lock flag, registered |

## Verification
The hardest situation to create is a cycle whose partner edge never arrives. The detector reports that cycle only after the timeout, which falls inside the next phase-detector period. Its effect on the flag therefore shows up one period late and is interleaved with the next measurement. The stimulus sometimes drops the reference edge or the feedback edge entirely. After such a drop, the check is held back until the end of the following period, where the model has applied both classifications in order. Directed periods place errors exactly on both thresholds and on either side of them, with both edge orders.

// File: rtl/phase_lock_pkg.sv
package phase_lock_pkg;

  typedef enum logic [1:0] {
    MS_IDLE     = 2'd0,
    MS_WAIT_FB  = 2'd1,
    MS_WAIT_REF = 2'd2
  } meter_state_t;

  typedef enum logic [1:0] {
    ERR_SMALL = 2'd0,
    ERR_MID   = 2'd1,
    ERR_LARGE = 2'd2
  } err_class_t;

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (clr) chain <= '0;
        else     chain <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (clr) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise_pulse = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/phase_err_meter.sv
module phase_err_meter
  import phase_lock_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 40,
  parameter int CNT_W         = $clog2(TIMEOUT_TICKS + 1)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  output logic             meas_valid,
  output logic             meas_miss,
  output logic [CNT_W-1:0] meas_err
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_TICKS);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  meter_state_t     state_q;
  logic [CNT_W-1:0] wait_cnt;

  logic lead_pulse, partner_pulse;

  always_comb begin
    lead_pulse    = 1'b0;
    partner_pulse = 1'b0;
    if (state_q == MS_WAIT_FB) begin
      lead_pulse    = ref_pulse;
      partner_pulse = fb_pulse;
    end else if (state_q == MS_WAIT_REF) begin
      lead_pulse    = fb_pulse;
      partner_pulse = ref_pulse;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      state_q    <= MS_IDLE;
      wait_cnt   <= '0;
      meas_valid <= 1'b0;
      meas_miss  <= 1'b0;
      meas_err   <= '0;
    end else begin
      meas_valid <= 1'b0;
      meas_miss  <= 1'b0;
      case (state_q)
        MS_IDLE: begin
          if (ref_pulse && fb_pulse) begin
            meas_valid <= 1'b1;
            meas_err   <= '0;
          end else if (ref_pulse) begin
            state_q  <= MS_WAIT_FB;
            wait_cnt <= ONE;
          end else if (fb_pulse) begin
            state_q  <= MS_WAIT_REF;
            wait_cnt <= ONE;
          end
        end
        default: begin
          if (partner_pulse) begin
            meas_valid <= 1'b1;
            meas_err   <= wait_cnt;
            if (lead_pulse) wait_cnt <= ONE;
            else            state_q  <= MS_IDLE;
          end else if (lead_pulse) begin
            meas_valid <= 1'b1;
            meas_miss  <= 1'b1;
            meas_err   <= wait_cnt;
            wait_cnt   <= ONE;
          end else if (wait_cnt >= LIMIT) begin
            meas_valid <= 1'b1;
            meas_miss  <= 1'b1;
            meas_err   <= wait_cnt;
            state_q    <= MS_IDLE;
          end else begin
            wait_cnt <= wait_cnt + ONE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lock_hysteresis.sv
module lock_hysteresis
  import phase_lock_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int SET_TICKS = 15,
  parameter int CLR_TICKS = 25,
  parameter int RUN_LO    = 3,
  parameter int RUN_HI    = 5,
  parameter int RUN_W     = $clog2(RUN_HI + 1)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             precise_sel,
  input  logic             meas_valid,
  input  logic             meas_miss,
  input  logic [CNT_W-1:0] meas_err,
  output logic             lock_q
);
  localparam logic [RUN_W-1:0] NEED_LO = RUN_W'(RUN_LO);
  localparam logic [RUN_W-1:0] NEED_HI = RUN_W'(RUN_HI);

  err_class_t       cls;
  logic [RUN_W-1:0] run_q, run_next, need;

  always_comb begin
    if (meas_miss || 32'(meas_err) > CLR_TICKS) cls = ERR_LARGE;
    else if (32'(meas_err) < SET_TICKS)         cls = ERR_SMALL;
    else                                        cls = ERR_MID;
    need     = precise_sel ? NEED_HI : NEED_LO;
    run_next = (run_q >= NEED_HI) ? NEED_HI : run_q + RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (meas_valid) begin
      case (cls)
        ERR_SMALL: begin
          run_q <= run_next;
          if (run_next >= need) lock_q <= 1'b1;
        end
        ERR_MID:   run_q <= '0;
        default: begin
          run_q  <= '0;
          lock_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor #(
  parameter int SYNC_STAGES   = 2,
  parameter int SET_TICKS     = 15,
  parameter int CLR_TICKS     = 25,
  parameter int TIMEOUT_TICKS = 40,
  parameter int RUN_LO        = 3,
  parameter int RUN_HI        = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_down,
  input  logic precise_sel,
  input  logic ref_div_in,
  input  logic fb_div_in,
  output logic lock_out
);
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);

  logic             clr;
  logic [1:0]       raw_in;
  logic [1:0]       rise;
  logic             meas_valid, meas_miss;
  logic [CNT_W-1:0] meas_err;

  assign clr    = rst | pwr_down;
  assign raw_in = {fb_div_in, ref_div_in};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_sync
      edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .clr       (clr),
        .async_in  (raw_in[i]),
        .rise_pulse(rise[i])
      );
    end
  endgenerate

  phase_err_meter #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .CNT_W(CNT_W)) u_meter (
    .clk       (clk),
    .clr       (clr),
    .ref_pulse (rise[0]),
    .fb_pulse  (rise[1]),
    .meas_valid(meas_valid),
    .meas_miss (meas_miss),
    .meas_err  (meas_err)
  );

  lock_hysteresis #(
    .CNT_W(CNT_W), .SET_TICKS(SET_TICKS), .CLR_TICKS(CLR_TICKS),
    .RUN_LO(RUN_LO), .RUN_HI(RUN_HI)
  ) u_lock (
    .clk        (clk),
    .clr        (clr),
    .precise_sel(precise_sel),
    .meas_valid (meas_valid),
    .meas_miss  (meas_miss),
    .meas_err   (meas_err),
    .lock_q     (lock_out)
  );
endmodule

// File: rtl/phase_lock_checker.sv
module phase_lock_checker #(
  parameter int CNT_W     = 6,
  parameter int SET_TICKS = 15,
  parameter int CLR_TICKS = 25
) (
  input logic             clk,
  input logic             rst,
  input logic             pwr_down,
  input logic             lock_out,
  input logic             meas_valid,
  input logic             meas_miss,
  input logic [CNT_W-1:0] meas_err
);
  logic big, mid;
  assign big = meas_miss || 32'(meas_err) > CLR_TICKS;
  assign mid = !big && 32'(meas_err) >= SET_TICKS;

  // R1
  pwr_down_clears_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> !lock_out);

  // R5
  large_err_unlocks_chk: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && big) |=> !lock_out);

  // R4
  lock_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_out && !pwr_down && !(meas_valid && big)) |=> lock_out);

  // R2
  rise_needs_meas_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_out) |-> $past(meas_valid && !big && !mid));

  // R6
  mid_no_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && mid && !lock_out) |=> !lock_out);

  // R7
  miss_unlocks_chk: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && meas_miss) |=> !lock_out);
endmodule

bind phase_lock_monitor phase_lock_checker #(
  .CNT_W(CNT_W), .SET_TICKS(SET_TICKS), .CLR_TICKS(CLR_TICKS)
) u_checker (
  .clk       (clk),
  .rst       (rst),
  .pwr_down  (pwr_down),
  .lock_out  (lock_out),
  .meas_valid(meas_valid),
  .meas_miss (meas_miss),
  .meas_err  (meas_err)
);

// File: tb/phase_lock_monitor_bench.sv
module phase_lock_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD_T   = 64;
  localparam int REF_AT     = 24;
  localparam int HIGH_T     = 6;
  localparam int SET_T      = 15;
  localparam int CLR_T      = 25;

  logic clk = 1'b0, rst = 1'b1, pwr_down = 1'b0, precise_sel = 1'b0;
  logic ref_div_in = 1'b0, fb_div_in = 1'b0;
  logic lock_out;

  int checks = 0, errors = 0;
  int m_run = 0;
  bit m_lock = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_lock_monitor u_phase_lock_monitor (
    .clk(clk), .rst(rst), .pwr_down(pwr_down), .precise_sel(precise_sel),
    .ref_div_in(ref_div_in), .fb_div_in(fb_div_in), .lock_out(lock_out)
  );

  // 0 small, 1 middle band, 2 large
  function automatic int classify(int d, bit miss);
    int a = (d < 0) ? -d : d;
    if (miss || a > CLR_T) return 2;
    if (a < SET_T) return 0;
    return 1;
  endfunction

  function automatic void model_step(int cls);
    int need = precise_sel ? 5 : 3;
    if (cls == 0) begin
      m_run++;
      if (m_run >= need) m_lock = 1'b1;
    end else if (cls == 1) begin
      m_run = 0;
    end else begin
      m_run = 0;
      m_lock = 1'b0;
    end
  endfunction

  task automatic check(string req, bit exp);
    checks++;
    if (lock_out !== exp) begin
      errors++;
      $display("FAIL %s: lock_out=%0b expected=%0b", req, lock_out, exp);
    end
  endtask

  // one phase-detector period; d = fb offset from ref in ticks
  task automatic period(int d, bit drop_ref, bit drop_fb, string req, bit do_check);
    for (int t = 0; t < PERIOD_T; t++) begin
      @(negedge clk);
      ref_div_in = !drop_ref && t >= REF_AT && t < REF_AT + HIGH_T;
      fb_div_in  = !drop_fb && t >= REF_AT + d && t < REF_AT + d + HIGH_T;
    end
    model_step(classify(d, drop_ref || drop_fb));
    if (do_check) check(req, m_lock);
  endtask

  task automatic power_cycle(bit new_precise);
    @(negedge clk);
    pwr_down = 1'b1;
    precise_sel = new_precise;
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    pwr_down = 1'b0;
    m_run = 0;
    m_lock = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    check("R1", 1'b0);
    rst = 1'b0;

    // R2: three small errors with precise_sel = 0
    period(3, 0, 0, "R2", 1);
    period(-5, 0, 0, "R2", 1);
    check("R2", 1'b0);
    period(0, 0, 0, "R2", 1);
    check("R2", 1'b1);
    // R6/R4: middle band keeps lock
    period(20, 0, 0, "R6", 1);
    check("R4", 1'b1);
    // R9: exactly SET and exactly CLR are middle band
    period(15, 0, 0, "R9", 1);
    period(-25, 0, 0, "R9", 1);
    check("R9", 1'b1);
    // R5: one large error
    period(26, 0, 0, "R5", 1);
    check("R5", 1'b0);
    // R6: middle restarts the run
    period(2, 0, 0, "R6", 1);
    period(14, 0, 0, "R9", 1);
    period(-16, 0, 0, "R6", 1);
    period(1, 0, 0, "R6", 1);
    period(-14, 0, 0, "R8", 1);
    check("R6", 1'b0);
    period(0, 0, 0, "R6", 1);
    check("R6", 1'b1);

    // R3: five small errors with precise_sel = 1
    power_cycle(1'b1);
    for (int i = 0; i < 4; i++) period(i - 2, 0, 0, "R3", 1);
    check("R3", 1'b0);
    period(7, 0, 0, "R3", 1);
    check("R3", 1'b1);
    // R7: missing feedback; result lands in next period
    period(0, 0, 1, "R7", 0);
    period(1, 0, 0, "R7", 1);
    check("R7", 1'b0);
    // R7: missing reference
    power_cycle(1'b0);
    for (int i = 0; i < 3; i++) period(4, 0, 0, "R2", 1);
    check("R2", 1'b1);
    period(-3, 1, 0, "R7", 0);
    period(0, 0, 0, "R7", 1);
    check("R7", 1'b0);
    // R8: feedback-led small errors lock just as well
    for (int i = 0; i < 3; i++) period(-12, 0, 0, "R8", 1);
    check("R8", 1'b1);

    // random mix
    for (int k = 0; k < 250; k++) begin
      int d = int'($urandom_range(50)) - 20;
      int r = int'($urandom_range(99));
      bit dr = (r < 4);
      bit df = (r >= 4 && r < 8);
      if (r >= 96) power_cycle(1'($urandom_range(1)));
      if (r < 70) d = int'($urandom_range(28)) - 14;
      period(d, dr, df, "R5", !(dr || df));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule